// File: doc/BRIEF.md
# Write-Through Invalidating Snoop Controller

This block keeps one small direct-mapped cache coherent with main memory and with its peer caches on a shared bus. Memory is updated on every store, so a cache line is only ever valid or invalid. Loads that hit are answered locally in the cycle they are presented. Loads that miss fetch one word over the bus and fill the line. Stores always go out on the bus and never allocate a line. A snoop port watches the bus, and a write by any other cache to an address held here removes the local copy.

The address splits into an index (the low `INDEX_W` bits) and a tag (the remaining upper bits). The processor holds `cpuReq`, `cpuWe`, `cpuAddr` and `cpuWdata` steady until it samples `cpuStall` low at a rising edge. The bus is atomic: a transaction is issued in the cycle where `busReq` and `busGnt` are both high. A read transaction then waits for `busAck`, which carries `busRdata`. Every bus transaction, including this cache's own, appears on the snoop port together with the identifier of the cache that issued it.

Top module: `wt_snoop_cache`

## Requirements
- R1: After reset every line is invalid, so the first load to any address is a miss. With no request present, `cpuStall` and `busReq` are both low.
- R2: A load to an invalid line, or to a line whose tag differs, raises `busReq` and issues exactly one bus read (`busValid`=1, `busWe`=0, `busAddr`=address). In the `busAck` cycle it returns `busRdata` with `cpuStall` low and marks the line valid with the new tag.
- R3: A load to a valid line whose tag matches completes in the cycle it is presented, with `cpuStall` low, no `busReq`, and the stored word on `cpuRdata`.
- R4: Every store issues exactly one bus write (`busWe`=1, with the store's address and data) and completes in its grant cycle. A store miss leaves the line invalid, and a store hit leaves it valid.
- R5: A store that hits a valid line updates the local copy in its grant cycle, so a later load hit returns the stored word.
- R6: A snooped write whose identifier differs from `CACHE_ID`, to an address whose indexed line is valid and whose tag matches, invalidates that line. The next load to that address is a miss and fetches the new value.
- R7: The following snoop events leave the line state unchanged, so a later load still hits: a snooped write carrying this cache's own identifier, any snooped read, and a snooped write to the same index with a different tag.
- R8: If a load and an invalidating snoop to the same line fall in the same cycle, the snoop wins and the load is served as a miss. A snoop to a different line in that cycle does not disturb a load hit.
- R9: `busValid` is only high while `busGnt` is high. No new bus request is raised while a read is waiting for `busAck`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cpuReq | input | 1 | Processor request, held until accepted |
| cpuWe | input | 1 | 1 = store, 0 = load |
| cpuAddr | input | ADDR_W | Processor word address |
| cpuWdata | input | DATA_W | Store data |
| cpuRdata | output | DATA_W | Load data, valid when `cpuStall` is low |
| cpuStall | output | 1 | Request not yet complete |
| busReq | output | 1 | Bus request to the arbiter |
| busGnt | input | 1 | Bus grant |
| busValid | output | 1 | Transaction issued this cycle |
| busWe | output | 1 | 1 = bus write, 0 = bus read |
| busAddr | output | ADDR_W | Bus address |
| busWdata | output | DATA_W | Bus write data |
| busRdata | input | DATA_W | Read response data |
| busAck | input | 1 | Read response strobe |
| snpValid | input | 1 | Snooped transaction present |
| snpWe | input | 1 | Snooped transaction is a write |
| snpId | input | ID_W | Identifier of the issuing cache |
| snpAddr | input | ADDR_W | Snooped address |

## Verification
A load hit and an invalidating snoop can land on the same line in the same cycle. This is the case where a stale word could leak out. The bench provokes it by presenting a load to a valid line at the same clock edge where it injects a peer write to that address. Because the peer owns the bus in that cycle, the grant is withheld. The reference model applies the invalidation first and predicts a miss, so the bench expects a bus request and the peer's new word as the load result. The same stimulus is repeated with the snoop aimed at a different index, and there the load must still hit locally.

// File: rtl/wtsc_pkg.sv
package wtsc_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic snpKill;    // invalidate the snooped line
    logic fill;       // install bus read data into the cpu line
    logic wrUpd;      // store hit: refresh local copy
    logic rdFromBus;  // route bus read data to cpu
  } wtscStrobe_t;

  typedef enum logic {ST_IDLE, ST_WAIT} wtscState_t;
endpackage

// File: rtl/wtsc_datapath.sv
module wtsc_datapath
  import wtsc_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 16,
  parameter int INDEX_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  wtscStrobe_t       strobe,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  input  logic [ADDR_W-1:0] snpAddr,
  input  logic [DATA_W-1:0] busRdata,
  output logic              cpuLineHit,
  output logic              snpLineHit,
  output logic              sameLine,
  output logic [DATA_W-1:0] cpuRdata
);
  localparam int LINES = 1 << INDEX_W;
  localparam int TAG_W = ADDR_W - INDEX_W;

  logic [LINES-1:0]  vld;
  logic [TAG_W-1:0]  tagArr [LINES];
  logic [DATA_W-1:0] datArr [LINES];

  logic [INDEX_W-1:0] cpuIdx, snpIdx;
  logic [TAG_W-1:0]   cpuTag, snpTag;

  assign cpuIdx = cpuAddr[INDEX_W-1:0];
  assign snpIdx = snpAddr[INDEX_W-1:0];
  assign cpuTag = cpuAddr[ADDR_W-1:INDEX_W];
  assign snpTag = snpAddr[ADDR_W-1:INDEX_W];

  // Valid bits: fill after kill so a fill of the same line is the later event
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vld <= '0;
    end else begin
      if (strobe.snpKill) vld[snpIdx] <= 1'b0;
      if (strobe.fill)    vld[cpuIdx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.fill) begin
      tagArr[cpuIdx] <= cpuTag;
      datArr[cpuIdx] <= busRdata;
    end else if (strobe.wrUpd) begin
      datArr[cpuIdx] <= cpuWdata;
    end
  end

  assign cpuLineHit = vld[cpuIdx] && (tagArr[cpuIdx] == cpuTag);
  assign snpLineHit = vld[snpIdx] && (tagArr[snpIdx] == snpTag);
  assign sameLine   = (cpuIdx == snpIdx);
  assign cpuRdata   = strobe.rdFromBus ? busRdata : datArr[cpuIdx];

  // R6: an invalidating snoop leaves the line invalid
  assert_kill_clears_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.snpKill && !(strobe.fill && sameLine)) |=> !vld[$past(snpIdx)]);

  // R2: a fill leaves the line valid with the requested tag
  assert_fill_installs_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fill |=> (vld[$past(cpuIdx)] && tagArr[$past(cpuIdx)] == $past(cpuTag)));
endmodule

// File: rtl/wtsc_ctrl.sv
module wtsc_ctrl
  import wtsc_pkg::*;
#(
  parameter int ID_W     = 2,
  parameter int CACHE_ID = 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            cpuReq,
  input  logic            cpuWe,
  input  logic            cpuLineHit,
  input  logic            snpLineHit,
  input  logic            sameLine,
  input  logic            snpValid,
  input  logic            snpWe,
  input  logic [ID_W-1:0] snpId,
  input  logic            busGnt,
  input  logic            busAck,
  output wtscStrobe_t     strobe,
  output logic            cpuStall,
  output logic            busReq,
  output logic            busValid,
  output logic            busWe
);
  wtscState_t state, stateNxt;
  logic snpOther, killNow, hitNow, idle;

  assign idle     = (state == ST_IDLE);
  assign snpOther = snpValid && snpWe && (snpId != ID_W'(CACHE_ID));
  assign killNow  = snpOther && snpLineHit;
  // a same-cycle invalidation of the cpu line wins over the hit
  assign hitNow   = cpuLineHit && !(killNow && sameLine);

  assign busReq   = idle && cpuReq && (cpuWe || !hitNow);
  assign busValid = busReq && busGnt;
  assign busWe    = busValid && cpuWe;

  always_comb begin
    strobe           = '0;
    strobe.snpKill   = killNow;
    strobe.fill      = !idle && busAck;
    strobe.wrUpd     = busValid && cpuWe && hitNow;
    strobe.rdFromBus = !idle;
  end

  always_comb begin
    if (idle) cpuStall = cpuReq && !((!cpuWe && hitNow) || (cpuWe && busGnt));
    else      cpuStall = !busAck;
  end

  always_comb begin
    stateNxt = state;
    if (idle && busValid && !cpuWe) stateNxt = ST_WAIT;
    else if (!idle && busAck)       stateNxt = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  assert_hit_local_R3: assert property (@(posedge clk) disable iff (!rstN)
    (idle && cpuReq && !cpuWe && cpuLineHit && !killNow) |-> (!busReq && !cpuStall));

  assert_store_on_bus_R4: assert property (@(posedge clk) disable iff (!rstN)
    (cpuReq && cpuWe && !cpuStall) |-> (busValid && busWe));

  assert_grant_only_R9: assert property (@(posedge clk) disable iff (!rstN)
    busValid |-> busGnt);

  assert_one_outstanding_R9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT) |-> !busReq);

  assert_ignore_own_or_read_R7: assert property (@(posedge clk) disable iff (!rstN)
    (snpValid && (!snpWe || snpId == ID_W'(CACHE_ID))) |-> !strobe.snpKill);

  assert_read_enters_wait_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busWe) |=> (state == ST_WAIT));
endmodule

// File: rtl/wt_snoop_cache.sv
module wt_snoop_cache
  import wtsc_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 16,
  parameter int INDEX_W  = 3,
  parameter int ID_W     = 2,
  parameter int CACHE_ID = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuReq,
  input  logic              cpuWe,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic [DATA_W-1:0] cpuRdata,
  output logic              cpuStall,
  output logic              busReq,
  input  logic              busGnt,
  output logic              busValid,
  output logic              busWe,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWdata,
  input  logic [DATA_W-1:0] busRdata,
  input  logic              busAck,
  input  logic              snpValid,
  input  logic              snpWe,
  input  logic [ID_W-1:0]   snpId,
  input  logic [ADDR_W-1:0] snpAddr
);
  wtscStrobe_t strobe;
  logic cpuLineHit, snpLineHit, sameLine;

  assign busAddr  = cpuAddr;
  assign busWdata = cpuWdata;

  wtsc_ctrl #(.ID_W(ID_W), .CACHE_ID(CACHE_ID)) uCtrl (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWe(cpuWe),
    .cpuLineHit(cpuLineHit), .snpLineHit(snpLineHit), .sameLine(sameLine),
    .snpValid(snpValid), .snpWe(snpWe), .snpId(snpId),
    .busGnt(busGnt), .busAck(busAck), .strobe(strobe),
    .cpuStall(cpuStall), .busReq(busReq), .busValid(busValid), .busWe(busWe)
  );

  wtsc_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .INDEX_W(INDEX_W)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cpuAddr(cpuAddr),
    .cpuWdata(cpuWdata), .snpAddr(snpAddr), .busRdata(busRdata),
    .cpuLineHit(cpuLineHit), .snpLineHit(snpLineHit), .sameLine(sameLine),
    .cpuRdata(cpuRdata)
  );
endmodule

// File: tb/tb_wt_snoop_cache.sv
module tb_wt_snoop_cache;
  localparam int CLK_P = 10;
  localparam int ADDR_W = 8, DATA_W = 16, INDEX_W = 3, ID_W = 2, CACHE_ID = 1;
  localparam int LINES = 1 << INDEX_W;

  logic clk = 0, rstN = 0;
  logic cpuReq = 0, cpuWe = 0;
  logic [ADDR_W-1:0] cpuAddr = '0;
  logic [DATA_W-1:0] cpuWdata = '0, cpuRdata;
  logic cpuStall, busReq, busGnt, busValid, busWe, busAck;
  logic [ADDR_W-1:0] busAddr;
  logic [DATA_W-1:0] busWdata, busRdata;
  logic snpValid, snpWe;
  logic [ID_W-1:0] snpId;
  logic [ADDR_W-1:0] snpAddr;
  logic othValid = 0, othWe = 0;
  logic [ID_W-1:0] othId = 2;
  logic [ADDR_W-1:0] othAddr = '0;
  logic [DATA_W-1:0] othData = '0;

  int checks = 0, errors = 0;
  bit finished = 0;
  int memArr [256];
  int refMem [256];
  bit mValid [LINES];
  int mTag [LINES];

  always #(CLK_P/2) clk = ~clk;

  wt_snoop_cache #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .INDEX_W(INDEX_W),
                   .ID_W(ID_W), .CACHE_ID(CACHE_ID)) dut (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWe(cpuWe), .cpuAddr(cpuAddr),
    .cpuWdata(cpuWdata), .cpuRdata(cpuRdata), .cpuStall(cpuStall),
    .busReq(busReq), .busGnt(busGnt), .busValid(busValid), .busWe(busWe),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .busAck(busAck),
    .snpValid(snpValid), .snpWe(snpWe), .snpId(snpId), .snpAddr(snpAddr)
  );

  // arbiter: a peer transaction holds the bus in its cycle
  assign busGnt   = busReq && !othValid;
  assign snpValid = busValid || othValid;
  assign snpWe    = busValid ? busWe : othWe;
  assign snpId    = busValid ? ID_W'(CACHE_ID) : othId;
  assign snpAddr  = busValid ? busAddr : othAddr;

  // memory model
  initial for (int i = 0; i < 256; i++) begin
    memArr[i] = (i * 37 + 5) & 16'hffff;
    refMem[i] = memArr[i];
  end
  always @(posedge clk) begin
    busAck <= 1'b0;
    if (busValid && !busWe) begin
      busAck   <= 1'b1;
      busRdata <= DATA_W'(memArr[busAddr]);
    end
    if (busValid && busWe) memArr[busAddr] <= int'(busWdata);
    if (othValid && othWe && othId != ID_W'(CACHE_ID)) memArr[othAddr] <= int'(othData);
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // Processor operation, optionally with a peer snoop write in its first cycle
  task automatic cpuOp(input bit we, input int addr, input int wdata, input string req,
                       input bit race = 0, input int sAddr = 0, input int sData = 0);
    int cycles = 0, reqSeen = 0, txn = 0, rd = 0, idx, tg;
    bit done = 0, expHit;
    @(negedge clk);
    cpuReq = 1; cpuWe = we; cpuAddr = ADDR_W'(addr); cpuWdata = DATA_W'(wdata);
    if (race) begin
      othValid = 1; othWe = 1; othId = 2;
      othAddr = ADDR_W'(sAddr); othData = DATA_W'(sData);
      refMem[sAddr] = sData;
      if (mValid[sAddr % LINES] && mTag[sAddr % LINES] == sAddr / LINES)
        mValid[sAddr % LINES] = 0;
    end
    idx = addr % LINES; tg = addr / LINES;
    expHit = mValid[idx] && mTag[idx] == tg;
    while (!done && cycles < 50) begin
      #(CLK_P/2 - 1);
      if (busValid) begin
        txn++;
        check(busGnt == 1, "R9 issue without grant", int'(busGnt), 1);
        check(int'(busAddr) == addr, "R4/R2 bus address", int'(busAddr), addr);
        check(busWe == we, "R4/R2 bus direction", int'(busWe), int'(we));
        if (we) check(int'(busWdata) == wdata, "R4 bus write data", int'(busWdata), wdata);
      end else if (busReq) begin
        check(txn == 0, "R9 request while read outstanding", txn, 0);
      end
      if (busReq) reqSeen++;
      if (!cpuStall) begin done = 1; rd = int'(cpuRdata); end
      cycles++;
      @(negedge clk);
      othValid = 0;
    end
    cpuReq = 0;
    check(done, "watchdog on cpu request", cycles, 50);
    check(txn == ((we || !expHit) ? 1 : 0), {req, " bus transaction count"}, txn,
          (we || !expHit) ? 1 : 0);
    if (we) begin
      refMem[addr] = wdata;
    end else begin
      check((reqSeen == 0) == expHit, {req, expHit ? " R3 hit local" : " R2 miss on bus"},
            reqSeen, expHit ? 0 : 1);
      check(rd == refMem[addr], {req, " load data"}, rd, refMem[addr]);
      mValid[idx] = 1; mTag[idx] = tg;
    end
  endtask

  task automatic peerSnoop(input bit we, input int addr, input int data, input int id);
    @(negedge clk);
    othValid = 1; othWe = we; othId = ID_W'(id);
    othAddr = ADDR_W'(addr); othData = DATA_W'(data);
    #(CLK_P/2 - 1);
    check(!busReq && !cpuStall, "R7 idle during snoop", int'(busReq), 0);
    @(negedge clk);
    othValid = 0;
    if (we && id != CACHE_ID) begin
      refMem[addr] = data;
      if (mValid[addr % LINES] && mTag[addr % LINES] == addr / LINES)
        mValid[addr % LINES] = 0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(0, "watchdog global", 0, 1);
    finish_run();
  end

  initial begin
    for (int i = 0; i < LINES; i++) begin mValid[i] = 0; mTag[i] = 0; end
    repeat (3) @(negedge clk);
    #(CLK_P/2 - 1);
    check(!busReq && !cpuStall, "R1 reset outputs", int'(busReq), 0);
    @(negedge clk); rstN = 1;
    @(negedge clk);
    check(!busReq && !cpuStall, "R1 idle after reset", int'(cpuStall), 0);

    cpuOp(0, 'h10, 0, "R1 first load");
    cpuOp(0, 'h13, 0, "R2 load miss");
    cpuOp(0, 'h13, 0, "R3 load hit");
    cpuOp(1, 'h13, 'h1234, "R4 store hit");
    cpuOp(0, 'h13, 0, "R5 load after store hit");
    cpuOp(1, 'h25, 'h0bad, "R4 store miss");
    cpuOp(0, 'h25, 0, "R4 no allocate");
    peerSnoop(1, 'h2d, 'h7777, 2);
    cpuOp(0, 'h25, 0, "R7 other tag ignored");
    peerSnoop(0, 'h25, 0, 2);
    cpuOp(0, 'h25, 0, "R7 snoop read ignored");
    peerSnoop(1, 'h25, 'h4444, CACHE_ID);
    cpuOp(0, 'h25, 0, "R7 own id ignored");
    peerSnoop(1, 'h25, 'h5a5a, 3);
    cpuOp(0, 'h25, 0, "R6 invalidated reload");
    cpuOp(0, 'h13, 0, "R8 race same line", 1, 'h13, 'h6161);
    cpuOp(0, 'h13, 0, "R8 race different line", 1, 'h40, 'h2222);
    cpuOp(0, 'h13, 0, "R8 after race");
    for (int i = 0; i < 24; i++) begin
      cpuOp(0, (i * 11) & 255, 0, "R2 sweep");
      if (i % 3 == 0) cpuOp(1, (i * 11) & 255, i * 91, "R5 sweep store");
      if (i % 4 == 1) peerSnoop(1, (i * 11) & 255, i * 7 + 1, 0);
      cpuOp(0, (i * 11) & 255, 0, "R6 sweep reread");
    end
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule